// File: doc/BRIEF.md
# Packet Buffer Page Allocator

This block keeps track of a small packet RAM split into 256-byte pages for a network controller. Software writes an 8-bit command word; the top three bits choose an operation and, for allocation, the low bits give the page count minus one. A successful allocation claims the lowest-numbered free pages for the lowest unused packet number, publishes that number in an allocation result byte and pulses an allocation-done event. A failed allocation sets bit 7 of the result byte instead.

Two packet-number queues sit beside the page table: a receive queue, filled by the receive side through a push input, and a transmit-completion queue, filled by the enqueue command. Their heads and empty flags are packed into one FIFO-ports word. Freeing a packet, either named in the packet-number register or taken from the head of the receive queue, returns its pages and holds a busy flag for a fixed number of cycles; commands written while busy are dropped. A memory-information word reports free and total page counts.

Top module: `pktbuf_alloc`

## Requirements
- R1: After reset, mem_info reads 16'h1010 (free pages in [15:8], total pages in [7:0]), fifo_ports reads 16'h8080, alloc_result reads 8'h80, busy and alloc_irq are 0.
- R2: An accepted command with bits [7:5]=001 and bits [2:0]=n-1 claims the n lowest-numbered free pages for the lowest packet number that owns no page; one cycle after the strobe alloc_result holds that number with bit 7 clear, the free count has dropped by n, and alloc_irq is high for exactly that one cycle.
- R3: An allocate command asking for more pages than are free leaves all pages untouched, sets alloc_result to 8'h80 and raises no alloc_irq.
- R4: Command 101 frees every page owned by the packet number in the packet-number register; one cycle later the free count includes those pages and busy is high for exactly 4 cycles.
- R5: A command written while busy is high has no effect: the result byte, free count and alloc_irq stay as they were.
- R6: A receive push appends a packet number to the receive queue; fifo_ports[14:8] shows the oldest entry and bit 15 is set when the queue is empty (head field 0), in arrival order.
- R7: Command 011 removes the receive head without freeing its pages and without raising busy.
- R8: Command 100 removes the receive head and frees its pages, raising busy as R4.
- R9: Command 110 appends the packet-number register to the transmit-completion queue; fifo_ports[6:0] shows its head and bit 7 is set when it is empty.
- R10: Command 111 empties the transmit-completion queue and leaves the receive queue intact.
- R11: Command 010 frees all pages and empties both queues.
- R12: Command 000 changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Single-cycle command write strobe |
| cmd_wdata | input | 8 | Command word: [7:5] operation, [2:0] pages minus one |
| pnr_we | input | 1 | Packet-number register write strobe |
| pnr_wdata | input | 7 | Packet number to load |
| rx_push | input | 1 | Append rx_pkt to the receive queue |
| rx_pkt | input | 7 | Packet number of an arriving frame |
| busy | output | 1 | High while a release is in progress |
| alloc_result | output | 8 | Bit 7 failure, [6:0] allocated packet number |
| alloc_irq | output | 1 | One-cycle allocation-done event |
| fifo_ports | output | 16 | {rx_empty, rx_head[6:0], tx_empty, tx_head[6:0]} |
| mem_info | output | 16 | {free pages, total pages} |

## Verification
Every result of an accepted command is registered once, so alloc_result, alloc_irq, mem_info and fifo_ports are due on the first falling edge after the clock edge that takes the strobe; the bench drives on falling edges and reads at the very next one. The busy flag is sampled on each of the following falling edges and must read 1 four times, then 0. Commands slipped in during busy are checked at the sample after their own edge, and alloc_irq is read a second time one cycle later to confirm it is a single pulse.

// File: rtl/pba_pkg.sv
package pba_pkg;
   localparam int NUM_W = 7;

   typedef enum logic [2:0] {
      OP_NOP     = 3'd0,
      OP_ALLOC   = 3'd1,
      OP_RESET   = 3'd2,
      OP_REMOVE  = 3'd3,
      OP_REMFREE = 3'd4,
      OP_FREE    = 3'd5,
      OP_ENQ     = 3'd6,
      OP_TXRST   = 3'd7
   } cmd_op_e;
endpackage

// File: rtl/pba_fifo.sv
module pba_fifo #(
   parameter int DEPTH = 16,
   parameter int W     = 7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] head,
   output logic         empty,
   output logic         full
);
   localparam int AW = $clog2(DEPTH);

   logic [W-1:0] mem [DEPTH];
   logic [AW:0]  wp_q, rp_q;

   assign empty = (wp_q == rp_q);
   assign full  = (wp_q[AW] != rp_q[AW]) && (wp_q[AW-1:0] == rp_q[AW-1:0]);
   assign head  = empty ? '0 : mem[rp_q[AW-1:0]];

   always_ff @(posedge clk) begin
      if (push && !full) mem[wp_q[AW-1:0]] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         wp_q <= '0;
         rp_q <= '0;
      end else begin
         if (push && !full) wp_q <= wp_q + 1'b1;
         if (pop && !empty) rp_q <= rp_q + 1'b1;
      end
   end
endmodule

// File: rtl/pba_pages.sv
module pba_pages #(
   parameter int PAGES = 16,
   parameter int PKTS  = 16,
   parameter int NUM_W = 7,
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             alloc_go,
   input  logic [CNT_W-1:0] need,
   output logic             alloc_ok,
   output logic [NUM_W-1:0] alloc_num,
   input  logic             free_go,
   input  logic [NUM_W-1:0] free_num,
   output logic [CNT_W-1:0] free_cnt
);
   localparam int ID_W = $clog2(PKTS);

   logic [PAGES-1:0] used_q;
   logic [ID_W-1:0]  owner_q [PAGES];
   logic [PAGES-1:0] take;
   logic [PKTS-1:0]  id_busy;
   logic [ID_W-1:0]  pick_id;
   logic             id_ok;
   logic [CNT_W-1:0] cnt_c;

   always_comb begin
      cnt_c = '0;
      take  = '0;
      for (int i = 0; i < PAGES; i++) begin
         if (!used_q[i]) begin
            if (cnt_c < need) take[i] = 1'b1;
            cnt_c = cnt_c + 1'b1;
         end
      end
   end

   always_comb begin
      id_busy = '0;
      for (int i = 0; i < PAGES; i++)
         if (used_q[i]) id_busy[owner_q[i]] = 1'b1;
      id_ok   = 1'b0;
      pick_id = '0;
      for (int p = PKTS - 1; p >= 0; p--) begin
         if (!id_busy[p]) begin
            id_ok   = 1'b1;
            pick_id = ID_W'(p);
         end
      end
   end

   assign free_cnt  = cnt_c;
   assign alloc_ok  = id_ok && (cnt_c >= need);
   assign alloc_num = NUM_W'(pick_id);

   for (genvar g = 0; g < PAGES; g++) begin : g_page
      always_ff @(posedge clk) begin
         if (!rst_n || clr) begin
            used_q[g]  <= 1'b0;
            owner_q[g] <= '0;
         end else if (alloc_go && alloc_ok && take[g]) begin
            used_q[g]  <= 1'b1;
            owner_q[g] <= pick_id;
         end else if (free_go && used_q[g] && (NUM_W'(owner_q[g]) == free_num)) begin
            used_q[g]  <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/pktbuf_alloc.sv
module pktbuf_alloc #(
   parameter int PAGES    = 16,
   parameter int PKTS     = 16,
   parameter int QDEPTH   = 16,
   parameter int REQ_W    = 3,
   parameter int BUSY_CYC = 4
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cmd_we,
   input  logic [7:0]  cmd_wdata,
   input  logic        pnr_we,
   input  logic [6:0]  pnr_wdata,
   input  logic        rx_push,
   input  logic [6:0]  rx_pkt,
   output logic        busy,
   output logic [7:0]  alloc_result,
   output logic        alloc_irq,
   output logic [15:0] fifo_ports,
   output logic [15:0] mem_info
);
   import pba_pkg::*;

   localparam int CNT_W = $clog2(PAGES + 1);
   localparam int BSY_W = $clog2(BUSY_CYC + 1);

   if (PAGES < 1 || PAGES > 255) begin : g_bad_pages
      $error("PAGES must lie in 1..255");
   end
   if (PKTS < 2 || PKTS > 128 || (2 ** $clog2(PKTS)) != PKTS) begin : g_bad_pkts
      $error("PKTS must be a power of two in 2..128");
   end
   if (REQ_W < 1 || REQ_W >= CNT_W + 1) begin : g_bad_req
      $error("REQ_W out of range");
   end
   if (QDEPTH < 2 || (2 ** $clog2(QDEPTH)) != QDEPTH) begin : g_bad_q
      $error("QDEPTH must be a power of two of at least 2");
   end
   if (BUSY_CYC < 1) begin : g_bad_busy
      $error("BUSY_CYC must be at least 1");
   end

   cmd_op_e          op;
   logic             accept;
   logic             alloc_go, alloc_ok, clr_all, free_go, rx_free;
   logic [CNT_W-1:0] need, free_cnt;
   logic [NUM_W-1:0] alloc_num, free_num, pnr_q;
   logic [NUM_W-1:0] rx_head, tx_head;
   logic             rx_empty, tx_empty, rx_full, tx_full;
   logic [BSY_W-1:0] bsy_q;
   logic [7:0]       res_q;
   logic             irq_q;

   assign op       = cmd_op_e'(cmd_wdata[7:5]);
   assign busy     = (bsy_q != '0);
   assign accept   = cmd_we && !busy;
   assign alloc_go = accept && (op == OP_ALLOC);
   assign clr_all  = accept && (op == OP_RESET);
   assign need     = CNT_W'(cmd_wdata[REQ_W-1:0]) + 1'b1;
   assign rx_free  = accept && (op == OP_REMFREE) && !rx_empty;
   assign free_go  = rx_free || (accept && (op == OP_FREE));
   assign free_num = rx_free ? rx_head : pnr_q;

   pba_pages #(.PAGES(PAGES), .PKTS(PKTS), .NUM_W(NUM_W), .CNT_W(CNT_W)) i_pages (
      .clk(clk), .rst_n(rst_n), .clr(clr_all),
      .alloc_go(alloc_go), .need(need), .alloc_ok(alloc_ok), .alloc_num(alloc_num),
      .free_go(free_go), .free_num(free_num), .free_cnt(free_cnt)
   );

   pba_fifo #(.DEPTH(QDEPTH), .W(NUM_W)) i_rxq (
      .clk(clk), .rst_n(rst_n), .clr(clr_all),
      .push(rx_push), .din(rx_pkt),
      .pop(accept && (op == OP_REMOVE || op == OP_REMFREE)),
      .head(rx_head), .empty(rx_empty), .full(rx_full)
   );

   pba_fifo #(.DEPTH(QDEPTH), .W(NUM_W)) i_txq (
      .clk(clk), .rst_n(rst_n), .clr(clr_all || (accept && op == OP_TXRST)),
      .push(accept && (op == OP_ENQ)), .din(pnr_q),
      .pop(1'b0),
      .head(tx_head), .empty(tx_empty), .full(tx_full)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pnr_q <= '0;
         bsy_q <= '0;
         res_q <= 8'h80;
         irq_q <= 1'b0;
      end else begin
         if (pnr_we) pnr_q <= pnr_wdata;
         if (free_go)    bsy_q <= BSY_W'(BUSY_CYC);
         else if (busy)  bsy_q <= bsy_q - 1'b1;
         irq_q <= alloc_go && alloc_ok;
         if (alloc_go) res_q <= alloc_ok ? {1'b0, alloc_num} : 8'h80;
      end
   end

   assign alloc_result = res_q;
   assign alloc_irq    = irq_q;
   assign fifo_ports   = {rx_empty, rx_head, tx_empty, tx_head};
   assign mem_info     = {8'(free_cnt), 8'(PAGES)};
endmodule

// File: rtl/pba_checker.sv
module pba_checker #(
   parameter int BUSY_CYC = 4
) (
   input logic        clk,
   input logic        rst_n,
   input logic        cmd_we,
   input logic        busy,
   input logic [7:0]  alloc_result,
   input logic        alloc_irq,
   input logic [15:0] fifo_ports,
   input logic [15:0] mem_info
);
   logic [7:0] run_q;

   always_ff @(posedge clk) begin
      if (!rst_n)    run_q <= '0;
      else if (busy) run_q <= run_q + 1'b1;
      else           run_q <= '0;
   end

   AST_FREE_LE_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
      mem_info[15:8] <= mem_info[7:0]);                                   // R1
   AST_IRQ_HAS_NUMBER: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_irq |-> !alloc_result[7]);                                    // R2
   AST_IRQ_TAKES_PAGES: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(alloc_irq) |-> mem_info[15:8] < $past(mem_info[15:8]));       // R2
   AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> run_q < 8'(BUSY_CYC));                                     // R4
   AST_BUSY_FULL_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> run_q == 8'(BUSY_CYC));                             // R4
   AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cmd_we) |=> !alloc_irq && $stable(alloc_result) && $stable(mem_info[15:8])); // R5
   AST_RX_EMPTY_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_ports[15] |-> fifo_ports[14:8] == 7'd0);                       // R6
   AST_TX_EMPTY_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_ports[7] |-> fifo_ports[6:0] == 7'd0);                         // R9
endmodule

bind pktbuf_alloc pba_checker #(.BUSY_CYC(BUSY_CYC)) i_chk (
   .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .busy(busy),
   .alloc_result(alloc_result), .alloc_irq(alloc_irq),
   .fifo_ports(fifo_ports), .mem_info(mem_info)
);

// File: tb/test_pktbuf_alloc.sv
module test_pktbuf_alloc;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_we = 1'b0;
   logic [7:0]  cmd_wdata = '0;
   logic        pnr_we = 1'b0;
   logic [6:0]  pnr_wdata = '0;
   logic        rx_push = 1'b0;
   logic [6:0]  rx_pkt = '0;
   logic        busy, alloc_irq;
   logic [7:0]  alloc_result;
   logic [15:0] fifo_ports, mem_info;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   pktbuf_alloc i_pktbuf_alloc (
      .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
      .pnr_we(pnr_we), .pnr_wdata(pnr_wdata), .rx_push(rx_push), .rx_pkt(rx_pkt),
      .busy(busy), .alloc_result(alloc_result), .alloc_irq(alloc_irq),
      .fifo_ports(fifo_ports), .mem_info(mem_info)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic cmd(input logic [7:0] v);
      cmd_we = 1'b1; cmd_wdata = v;
      @(negedge clk);
      cmd_we = 1'b0; cmd_wdata = '0;
   endtask

   task automatic set_pnr(input logic [6:0] v);
      pnr_we = 1'b1; pnr_wdata = v;
      @(negedge clk);
      pnr_we = 1'b0;
   endtask

   task automatic push_rx(input logic [6:0] v);
      rx_push = 1'b1; rx_pkt = v;
      @(negedge clk);
      rx_push = 1'b0;
   endtask

   // called on the first sample after a freeing command: expects n more busy samples then 0
   task automatic busy_run(input string req, input int n);
      for (int i = 0; i < n; i++) begin
         chk(req, "busy held", int'(busy), 1);
         @(negedge clk);
      end
      chk(req, "busy released", int'(busy), 0);
   endtask

   task automatic t_reset();
      chk("R1", "mem_info", mem_info, 16'h1010);
      chk("R1", "fifo_ports", fifo_ports, 16'h8080);
      chk("R1", "alloc_result", alloc_result, 8'h80);
      chk("R1", "busy", int'(busy), 0);
      chk("R1", "alloc_irq", int'(alloc_irq), 0);
   endtask

   task automatic t_alloc();
      cmd(8'h21);
      chk("R2", "result 2 pages", alloc_result, 8'h00);
      chk("R2", "irq pulse", int'(alloc_irq), 1);
      chk("R2", "free after 2", mem_info, 16'h0E10);
      @(negedge clk);
      chk("R2", "irq single cycle", int'(alloc_irq), 0);
      cmd(8'h22);
      chk("R2", "result 3 pages", alloc_result, 8'h01);
      chk("R2", "free after 3", mem_info, 16'h0B10);
      cmd(8'h27);
      chk("R2", "result 8 pages", alloc_result, 8'h02);
      chk("R2", "free after 8", mem_info, 16'h0310);
   endtask

   task automatic t_alloc_fail();
      @(negedge clk);
      cmd(8'h23);
      chk("R3", "fail flag", alloc_result, 8'h80);
      chk("R3", "no irq", int'(alloc_irq), 0);
      chk("R3", "pages kept", mem_info, 16'h0310);
   endtask

   task automatic t_free();
      set_pnr(7'd1);
      cmd(8'hA0);
      chk("R4", "pages back", mem_info, 16'h0610);
      busy_run("R4", 4);
      cmd(8'h20);
      chk("R4", "reuse freed number", alloc_result, 8'h01);
      chk("R4", "free after reuse", mem_info, 16'h0510);
   endtask

   task automatic t_rx();
      push_rx(7'd0);
      chk("R6", "rx head first", fifo_ports, 16'h0080);
      push_rx(7'd2);
      chk("R6", "rx order kept", fifo_ports, 16'h0080);
      cmd(8'h60);
      chk("R7", "rx head after remove", fifo_ports, 16'h0280);
      chk("R7", "no pages freed", mem_info, 16'h0510);
      chk("R7", "no busy", int'(busy), 0);
      cmd(8'h80);
      chk("R8", "rx empty", fifo_ports, 16'h8080);
      chk("R8", "pages of pkt 2 back", mem_info, 16'h0D10);
      chk("R8", "busy", int'(busy), 1);
      cmd(8'h20);  // lands while busy
      chk("R5", "result kept", alloc_result, 8'h01);
      chk("R5", "free kept", mem_info, 16'h0D10);
      chk("R5", "no irq", int'(alloc_irq), 0);
      busy_run("R8", 3);
   endtask

   task automatic t_tx();
      push_rx(7'd6);
      set_pnr(7'd1);
      cmd(8'hC0);
      chk("R9", "tx head", fifo_ports, 16'h0601);
      set_pnr(7'd4);
      cmd(8'hC0);
      chk("R9", "tx head kept", fifo_ports, 16'h0601);
      cmd(8'hE0);
      chk("R10", "tx cleared rx kept", fifo_ports, 16'h0680);
   endtask

   task automatic t_nop_reset();
      cmd(8'h00);
      chk("R12", "fifo_ports", fifo_ports, 16'h0680);
      chk("R12", "mem_info", mem_info, 16'h0D10);
      chk("R12", "alloc_result", alloc_result, 8'h01);
      chk("R12", "busy", int'(busy), 0);
      cmd(8'h40);
      chk("R11", "all pages free", mem_info, 16'h1010);
      chk("R11", "queues empty", fifo_ports, 16'h8080);
      cmd(8'h20);
      chk("R11", "numbers restart", alloc_result, 8'h00);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_alloc();
      t_alloc_fail();
      t_free();
      t_rx();
      t_tx();
      t_nop_reset();
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         finish_run();
      end
   end
endmodule